// File: doc/BRIEF.md
# Port Change-Detect Interrupt Unit

This unit watches the upper half of an eight-bit input port and raises a shared, sticky change flag whenever an enabled pin moves to a new level, in either direction. The lower half of the port is ignored entirely. Each input passes through a two-flop synchronizer. The synchronized level is compared every cycle with the level seen one cycle earlier. Any difference on a pin whose enable bit is set marks a change event.

Software sets the per-pin enables through an eight-bit control register. Bits 7 to 4 map to pins 7 to 4, and bits 3 to 0 hold no storage. The flag stays set until software pulses a clear strobe. An interrupt request appears only while the group enable input and the flag are both high. A priority input steers the request onto the high-priority line or the low-priority line. After reset, the comparison stays off until the synchronizer and the last-value copy hold real samples, so no event is raised at start-up.

Top module: `port_change_detect`

## Requirements
- R1: Pins 3 to 0 of `pin_in` never set the flag, whatever their activity and whatever value is written to the control register.
- R2: A rising or falling level change on an enabled pin among 7 to 4 sets `chg_flag` after the third rising clock edge, counted from the pin change. The first of these three edges samples the new level. `chg_flag` is still 0 after the second edge.
- R3: Control bit k (k = 7..4) set to 1 enables change detection on pin k. When the bit is 0, a change on pin k does not set the flag.
- R4: `ctl_rdata` bits 7 to 4 return the enables, which a pulse on `ctl_wr` loads from `ctl_wdata[7:4]` at the next edge. `ctl_rdata` bits 3 to 0 always read 0, and writes to them have no effect.
- R5: While reset is low and right after it, the enables read 0, and `chg_flag`, `irq_hi` and `irq_lo` are all 0.
- R6: `irq_hi` or `irq_lo` is 1 only when `grp_en` is 1 and `chg_flag` is 1.
- R7: With a request pending, `prio_hi` = 1 drives `irq_hi` only, and `prio_hi` = 0 drives `irq_lo` only. The two lines are never high together.
- R8: `chg_flag` stays set with no clear. A one-cycle `flag_clr` pulse with no new change clears it at the next edge.
- R9: When a change event and `flag_clr` occur in the same cycle, `chg_flag` is set after that edge.
- R10: Pins held at any level through reset release produce no change event. This holds even with all enables set soon after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Asynchronous port levels |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read-back |
| grp_en | input | 1 | Group interrupt enable |
| prio_hi | input | 1 | 1 routes the request to the high line, 0 to the low line |
| flag_clr | input | 1 | Software flag-clear strobe |
| chg_flag | output | 1 | Sticky shared change flag |
| irq_hi | output | 1 | High-priority interrupt request |
| irq_lo | output | 1 | Low-priority interrupt request |

## Verification
A pin change is due on `chg_flag` after the third rising edge. The first edge fills the first synchronizer flop, the second exposes the difference, and the third registers the flag. The bench drives pins on falling edges, then checks the flag after two edges (still clear) and after three (final value). Writes and clears take effect after one edge, so they are checked at the next falling edge. The request lines are combinational from the flag and the inputs, so they are sampled one time step after those inputs change.

// File: rtl/port_change_detect.sv
module port_change_detect #(
  parameter int PORT_W      = 8,
  parameter int MON_LSB     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              ctl_wr,
  input  logic [PORT_W-1:0] ctl_wdata,
  output logic [PORT_W-1:0] ctl_rdata,
  input  logic              grp_en,
  input  logic              prio_hi,
  input  logic              flag_clr,
  output logic              chg_flag,
  output logic              irq_hi,
  output logic              irq_lo
);
  localparam int EN_W      = PORT_W - MON_LSB;
  localparam int PRIME_MAX = SYNC_STAGES + 1;
  localparam int CW        = $clog2(PRIME_MAX + 1);

  logic [EN_W-1:0] sync_q [SYNC_STAGES];
  logic [EN_W-1:0] pin_last;
  logic [EN_W-1:0] en_q;
  logic [CW-1:0]   prime_cnt;
  logic            primed;
  logic            chg_evt;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sync_q[i] <= '0;
      else if (i == 0)
        sync_q[i] <= pin_in[PORT_W-1:MON_LSB];
      else
        sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_last  <= '0;
      prime_cnt <= '0;
    end else begin
      pin_last <= sync_q[SYNC_STAGES-1];
      if (!primed) prime_cnt <= prime_cnt + 1'b1;
    end
  end

  assign primed  = (prime_cnt == CW'(PRIME_MAX));
  assign chg_evt = primed && |((sync_q[SYNC_STAGES-1] ^ pin_last) & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (ctl_wr) en_q <= ctl_wdata[PORT_W-1:MON_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_flag <= 1'b0;
    else        chg_flag <= chg_evt | (chg_flag & ~flag_clr);
  end

  assign ctl_rdata = {en_q, {MON_LSB{1'b0}}};
  assign irq_hi    = grp_en & chg_flag &  prio_hi;
  assign irq_lo    = grp_en & chg_flag & ~prio_hi;
endmodule

// File: rtl/port_change_detect_chk.sv
module port_change_detect_chk #(
  parameter int PORT_W  = 8,
  parameter int MON_LSB = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic [PORT_W-1:0] ctl_wdata,
  input logic [PORT_W-1:0] ctl_rdata,
  input logic              grp_en,
  input logic              flag_clr,
  input logic              chg_flag,
  input logic              irq_hi,
  input logic              irq_lo,
  input logic              chg_evt
);
  // R4
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_rdata == {$past(ctl_wdata[PORT_W-1:MON_LSB]), {MON_LSB{1'b0}}});
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi || irq_lo) |-> (grp_en && chg_flag));
  // R7
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_hi && irq_lo));
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !flag_clr) |=> chg_flag);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !chg_evt) |=> !chg_flag);
  // R9
  clr_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && chg_evt) |=> chg_flag);
  // R2
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_flag) |-> $past(chg_evt));
endmodule

bind port_change_detect port_change_detect_chk #(.PORT_W(PORT_W), .MON_LSB(MON_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .grp_en(grp_en), .flag_clr(flag_clr),
  .chg_flag(chg_flag), .irq_hi(irq_hi), .irq_lo(irq_lo), .chg_evt(chg_evt)
);

// File: tb/sim_port_change_detect.sv
`timescale 1ns/1ps
module sim_port_change_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       grp_en = 1'b0;
  logic       prio_hi = 1'b0;
  logic       flag_clr = 1'b0;
  logic       chg_flag, irq_hi, irq_lo;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  port_change_detect u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .grp_en(grp_en),
    .prio_hi(prio_hi), .flag_clr(flag_clr), .chg_flag(chg_flag),
    .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  // {enable write, pins before, pins after, expected flag}
  localparam logic [24:0] VEC [8] = '{
    {8'hF0, 8'h00, 8'h10, 1'b1},   // R2 rise on pin 4
    {8'hF0, 8'hFF, 8'h7F, 1'b1},   // R2 fall on pin 7
    {8'hFF, 8'h00, 8'h0F, 1'b0},   // R1 low pins only
    {8'h20, 8'h00, 8'h10, 1'b0},   // R3 pin 4 disabled
    {8'h20, 8'h00, 8'h20, 1'b1},   // R3 pin 5 enabled
    {8'h0F, 8'h00, 8'hF0, 1'b0},   // R4 low-bit write enables nothing
    {8'h80, 8'h55, 8'hD5, 1'b1},   // R3 pin 7 rise
    {8'h40, 8'hAA, 8'hA5, 1'b0}    // R1 upper pins steady
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    pin_in = 8'hFF;
    step(3);
    check("R5 rdata in reset", ctl_rdata, 8'h00);
    check("R5 flag/irq in reset", {5'b0, chg_flag, irq_hi, irq_lo}, 8'h00);
    rst_n = 1'b1;
    ctl_wr = 1'b1; ctl_wdata = 8'hF0; grp_en = 1'b1;
    step(1);
    ctl_wr = 1'b0;
    step(8);
    check("R10 no start-up event", {7'b0, chg_flag}, 8'h00);
    check("R5 no request after reset", {6'b0, irq_hi, irq_lo}, 8'h00);
    grp_en = 1'b0;

    for (int i = 0; i < 8; i++) begin
      logic [24:0] v;
      v = VEC[i];
      ctl_wr = 1'b1; ctl_wdata = v[24:17]; pin_in = v[16:9];
      step(1);
      ctl_wr = 1'b0;
      check("R4 read-back", ctl_rdata, {v[24:21], 4'h0});
      step(4);
      clear_flag();
      check("R8 cleared before change", {7'b0, chg_flag}, 8'h00);
      pin_in = v[8:1];
      step(2);
      check("R2 not before third edge", {7'b0, chg_flag}, 8'h00);
      step(1);
      check("R1/R2/R3 flag after change", {7'b0, chg_flag}, {7'b0, v[0]});
    end

    // R6 / R7 routing, flag set from last-but-one style change
    ctl_wr = 1'b1; ctl_wdata = 8'hF0; step(1); ctl_wr = 1'b0;
    step(3); clear_flag();
    pin_in = pin_in ^ 8'h40;
    step(3);
    grp_en = 1'b0; prio_hi = 1'b1; #1;
    check("R6 group disabled", {6'b0, irq_hi, irq_lo}, 8'h00);
    grp_en = 1'b1; #1;
    check("R7 high route", {6'b0, irq_hi, irq_lo}, 8'h02);
    prio_hi = 1'b0; #1;
    check("R7 low route", {6'b0, irq_hi, irq_lo}, 8'h01);

    // R8 sticky then clear
    step(10);
    check("R8 sticky", {7'b0, chg_flag}, 8'h01);
    clear_flag();
    check("R8 clear", {7'b0, chg_flag}, 8'h00);
    #1;
    check("R6 no request without flag", {6'b0, irq_hi, irq_lo}, 8'h00);

    // R9 clear collides with event
    pin_in = pin_in ^ 8'h80;
    @(posedge clk); @(posedge clk);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R9 event beats clear", {7'b0, chg_flag}, 8'h01);

    // R4 writes to low bits ignored in read-back
    ctl_wr = 1'b1; ctl_wdata = 8'h5A; step(1); ctl_wr = 1'b0;
    check("R4 low bits read 0", ctl_rdata, 8'h50);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule